// File: doc/BRIEF.md
# CPU-to-Co-processor Command and Bus-Takeover Bridge

This block sits between an 8-bit CPU bus running on a slow clock and a faster host co-processor on its own clock. On the CPU side it watches I/O port accesses. A small set of them is not a real data transfer: each is a request that the co-processor must service. The bridge latches such a request into a one-entry command register. The register holds the request until the host says it has finished with it, so the host can act on it at its own pace despite the difference between the two clocks.

On the host side the bridge takes one operation at a time. An operation can request the CPU bus, read or write memory or I/O space while the bus is granted, or give the bus back. When it gives the bus back, the host can choose to have a non-maskable interrupt pulse raised, which wakes a halted CPU. A further operation samples the CPU address bus for a bounded number of CPU cycles and reports whether the address went above a threshold. The host uses this to learn when the CPU has left a region of memory.

Every operation and every clear passes between the two clock domains as a toggle through two-flop synchronisers. The operation's fields are held steady in the host domain until the CPU side acknowledges the operation.

Top module: `cpbridge_top`

## Requirements
- R1: A CPU I/O read (`cpu_io_rd`) of port byte 0x17 (`cpu_addr[7:0]`) latches command code 1 (menu init). The host then sees `cmd_valid`=1 and `cmd_code`=1.
- R2: A CPU I/O read of port 0x19 latches code 2 (list a page of 16 file names), and a CPU I/O write of port 0x19 latches code 3 (load the selected file). Other port bytes, and a write to 0x17, latch nothing.
- R3: While a command is pending, further command accesses are ignored and the code does not change. A one-cycle `cmd_clear` pulse from the host removes the command, after which `cmd_valid` stays 0.
- R4: `cmd_valid` drops on the host clock after `cmd_clear` and stays low until the clear has been acknowledged across the domains. If a clear and a new command access land in the same CPU cycle, the new command is kept.
- R5: `op_kind`=0 (request) raises `busrq`. The operation completes only once `busak` is seen high.
- R6: `op_kind` 1/2/3/4 (memory read, memory write, I/O read, I/O write), while the bus is granted, drive `dma_addr`/`dma_dout` with exactly one one-cycle strobe on the matching line. Read data appears on `op_rdata`. No two strobes are ever high together.
- R7: A transfer issued while `busrq` and `busak` are not both high raises no strobe and completes with `op_rdata`=0.
- R8: `op_kind`=5 (release) drops `busrq`. With `op_nmi`=1, `nmi` is high for exactly NMI_CYCLES CPU cycles and never while `busrq` is high. With `op_nmi`=0, no `nmi` is raised.
- R9: `op_kind`=6 (address wait) samples `cpu_addr` on up to `op_tries` CPU cycles. It completes with `op_hit`=1 as soon as a sample is strictly greater than 0x5800; otherwise it completes with `op_hit`=0. An address equal to 0x5800 misses, and `op_tries`=0 misses at once.
- R10: `op_valid` is taken only while `op_busy` is 0. `op_busy` stays high until the cycle `op_done` pulses for one host cycle. `op_valid` raised while busy is ignored.
- R11: After reset, `busrq`, `nmi`, all strobes, `cmd_valid`, `op_busy` and `op_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Co-processor clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| cpu_clk | input | 1 | CPU bus clock |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| cpu_addr | input | 16 | CPU address bus (port byte in low 8 bits) |
| cpu_io_rd | input | 1 | CPU I/O read strobe |
| cpu_io_wr | input | 1 | CPU I/O write strobe |
| bus_din | input | 8 | Data returned by memory or I/O during a bridge read |
| busak | input | 1 | CPU bus acknowledge |
| busrq | output | 1 | CPU bus request |
| nmi | output | 1 | Non-maskable interrupt pulse to the CPU |
| dma_addr | output | 16 | Bridge-driven address |
| dma_dout | output | 8 | Bridge-driven write data |
| dma_mem_rd | output | 1 | Memory read strobe |
| dma_mem_wr | output | 1 | Memory write strobe |
| dma_io_rd | output | 1 | I/O read strobe |
| dma_io_wr | output | 1 | I/O write strobe |
| op_valid | input | 1 | Host issues an operation |
| op_kind | input | 3 | Operation code (0..6, see R5-R9) |
| op_addr | input | 16 | Transfer address |
| op_wdata | input | 8 | Transfer write data |
| op_nmi | input | 1 | Raise the interrupt on release |
| op_tries | input | 16 | Sample limit for the address wait |
| op_busy | output | 1 | Operation in flight |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | 8 | Read result |
| op_hit | output | 1 | Address-wait result |
| cmd_clear | input | 1 | Host clears the pending command |
| cmd_valid | output | 1 | A command is pending |
| cmd_code | output | 2 | Pending command code |

## Verification
The two functions that can meet in one CPU cycle are the host's clear, arriving through the synchroniser, and the decode of a new command access. The bench issues a clear and then starts a new command access at a sweep of CPU-cycle offsets, from one access placed before the clear to one placed well after it. An access that ends before the clear must leave the register empty once it settles. An access clear of the synchroniser window must leave the new code pending. In the offsets between, either outcome is allowed, but every cycle in which `cmd_valid` is high must show the new code.

// File: rtl/cpbridge_pkg.sv
package cpbridge_pkg;
  typedef enum logic [2:0] {
    OP_REQ  = 3'd0,
    OP_MRD  = 3'd1,
    OP_MWR  = 3'd2,
    OP_IRD  = 3'd3,
    OP_IWR  = 3'd4,
    OP_REL  = 3'd5,
    OP_WAIT = 3'd6
  } op_kind_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_INIT = 2'd1,
    CMD_LIST = 2'd2,
    CMD_LOAD = 2'd3
  } cmd_code_e;
endpackage

// File: rtl/cpbridge_sync.sv
module cpbridge_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cpbridge_cmd_latch.sv
module cpbridge_cmd_latch
  import cpbridge_pkg::*;
#(
  parameter logic [7:0] PORT_INIT  = 8'h17,
  parameter logic [7:0] PORT_FILES = 8'h19
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      io_rd,
  input  logic      io_wr,
  input  logic [7:0] port,
  input  logic      clr_tgl,
  output logic      pend,
  output cmd_code_e code,
  output logic      clr_ack_t
);
  logic      clr_s, clr_seen, clr_evt, hit;
  cmd_code_e new_code;

  cpbridge_sync #(.W(1)) u_clr_sync (.clk(clk), .rst(rst), .d(clr_tgl), .q(clr_s));

  assign clr_evt = clr_s ^ clr_seen;

  always_comb begin
    hit      = 1'b1;
    new_code = CMD_NONE;
    if (io_rd && port == PORT_INIT)       new_code = CMD_INIT;
    else if (io_rd && port == PORT_FILES) new_code = CMD_LIST;
    else if (io_wr && port == PORT_FILES) new_code = CMD_LOAD;
    else                                  hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      code      <= CMD_NONE;
      clr_seen  <= 1'b0;
      clr_ack_t <= 1'b0;
    end else begin
      clr_ack_t <= clr_seen;  // acknowledge one cycle after pend has dropped
      if (clr_evt) begin
        clr_seen <= clr_s;
        pend     <= hit;
        if (hit) code <= new_code;
      end else if (hit && !pend) begin
        pend <= 1'b1;
        code <= new_code;
      end
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr_evt) |=> (pend && $stable(code)));
  assert_same_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && hit) |=> pend);
endmodule

// File: rtl/cpbridge_dma_engine.sv
module cpbridge_dma_engine
  import cpbridge_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int TRY_W      = 16,
  parameter int NMI_CYCLES = 8,
  parameter int ADDR_LIMIT = 'h5800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_tgl,
  input  logic [2:0]       op_kind,
  input  logic [AW-1:0]    op_addr,
  input  logic [DW-1:0]    op_wdata,
  input  logic             op_nmi,
  input  logic [TRY_W-1:0] op_tries,
  output logic             ack_t,
  output logic [DW-1:0]    res_rdata,
  output logic             res_hit,
  input  logic             busak,
  input  logic [DW-1:0]    bus_din,
  input  logic [AW-1:0]    cpu_addr,
  output logic             busrq,
  output logic             nmi,
  output logic [AW-1:0]    dma_addr,
  output logic [DW-1:0]    dma_dout,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             io_rd,
  output logic             io_wr
);
  localparam int NC_W = $clog2(NMI_CYCLES + 1);
  localparam logic [AW-1:0] LIMIT = AW'(ADDR_LIMIT);

  typedef enum logic [2:0] {E_IDLE, E_GRANT, E_XFER, E_NMI, E_POLL} eng_st_e;

  eng_st_e          st;
  op_kind_e         kind;
  logic             req_s, req_seen, start;
  logic [TRY_W-1:0] cnt;
  logic [NC_W-1:0]  ncnt;

  cpbridge_sync #(.W(1)) u_req_sync (.clk(clk), .rst(rst), .d(req_tgl), .q(req_s));

  assign kind  = op_kind_e'(op_kind);
  assign start = req_s ^ req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE;  req_seen <= 1'b0;  ack_t <= 1'b0;
      busrq <= 1'b0; nmi <= 1'b0;
      {mem_rd, mem_wr, io_rd, io_wr} <= '0;
      dma_addr <= '0; dma_dout <= '0;
      res_rdata <= '0; res_hit <= 1'b0;
      cnt <= '0; ncnt <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          req_seen <= req_s;
          res_hit  <= 1'b0;
          case (kind)
            OP_REQ: begin busrq <= 1'b1; st <= E_GRANT; end
            OP_MRD, OP_MWR, OP_IRD, OP_IWR:
              if (busrq && busak) begin
                dma_addr <= op_addr;
                dma_dout <= op_wdata;
                mem_rd   <= (kind == OP_MRD);
                mem_wr   <= (kind == OP_MWR);
                io_rd    <= (kind == OP_IRD);
                io_wr    <= (kind == OP_IWR);
                st       <= E_XFER;
              end else begin
                res_rdata <= '0;
                ack_t     <= ~ack_t;
              end
            OP_REL: begin
              busrq <= 1'b0;
              if (op_nmi) begin
                nmi  <= 1'b1;
                ncnt <= NC_W'(NMI_CYCLES - 1);
                st   <= E_NMI;
              end else ack_t <= ~ack_t;
            end
            OP_WAIT: begin cnt <= op_tries; st <= E_POLL; end
            default: ack_t <= ~ack_t;
          endcase
        end
        E_GRANT: if (busak) begin ack_t <= ~ack_t; st <= E_IDLE; end
        E_XFER: begin
          if (mem_rd || io_rd) res_rdata <= bus_din;
          {mem_rd, mem_wr, io_rd, io_wr} <= '0;
          ack_t <= ~ack_t;
          st    <= E_IDLE;
        end
        E_NMI:
          if (ncnt == '0) begin
            nmi <= 1'b0; ack_t <= ~ack_t; st <= E_IDLE;
          end else ncnt <= ncnt - 1'b1;
        E_POLL:
          if (cnt == '0) begin
            ack_t <= ~ack_t; st <= E_IDLE;
          end else if (cpu_addr > LIMIT) begin
            res_hit <= 1'b1; ack_t <= ~ack_t; st <= E_IDLE;
          end else cnt <= cnt - 1'b1;
        default: st <= E_IDLE;
      endcase
    end
  end

  assert_wait_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (st == E_GRANT && !busak) |=> (st == E_GRANT && busrq));
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));
  assert_strobe_granted_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr || io_rd || io_wr) |-> (busrq && busak));
  assert_nmi_released_R8: assert property (@(posedge clk) disable iff (rst)
    nmi |-> !busrq);
  assert_poll_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (st == E_POLL && cnt != '0 && cpu_addr > LIMIT) |=> (res_hit && st == E_IDLE));
endmodule

// File: rtl/cpbridge_host_port.sv
module cpbridge_host_port #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int TRY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic [AW-1:0]    op_addr,
  input  logic [DW-1:0]    op_wdata,
  input  logic             op_nmi,
  input  logic [TRY_W-1:0] op_tries,
  output logic             op_busy,
  output logic             op_done,
  output logic [DW-1:0]    op_rdata,
  output logic             op_hit,
  input  logic             cmd_clear,
  output logic             cmd_valid,
  output logic [1:0]       cmd_code,
  output logic             req_tgl,
  output logic [2:0]       q_kind,
  output logic [AW-1:0]    q_addr,
  output logic [DW-1:0]    q_wdata,
  output logic             q_nmi,
  output logic [TRY_W-1:0] q_tries,
  input  logic             eng_ack_t,
  input  logic [DW-1:0]    eng_rdata,
  input  logic             eng_hit,
  output logic             clr_tgl,
  input  logic             lat_pend,
  input  logic [1:0]       lat_code,
  input  logic             lat_clr_ack_t
);
  logic ack_s, clr_ack_s, pend_s, ack_prev, clr_busy;

  cpbridge_sync #(.W(3)) u_back_sync (
    .clk(clk), .rst(rst),
    .d({eng_ack_t, lat_clr_ack_t, lat_pend}),
    .q({ack_s, clr_ack_s, pend_s}));

  assign op_busy  = req_tgl ^ ack_prev;
  assign clr_busy = clr_tgl ^ clr_ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl <= 1'b0; ack_prev <= 1'b0; op_done <= 1'b0;
      op_rdata <= '0;  op_hit <= 1'b0;
      q_kind <= '0; q_addr <= '0; q_wdata <= '0; q_nmi <= 1'b0; q_tries <= '0;
      clr_tgl <= 1'b0; cmd_valid <= 1'b0; cmd_code <= '0;
    end else begin
      if (op_valid && !op_busy) begin
        q_kind  <= op_kind;
        q_addr  <= op_addr;
        q_wdata <= op_wdata;
        q_nmi   <= op_nmi;
        q_tries <= op_tries;
        req_tgl <= ~req_tgl;
      end
      ack_prev <= ack_s;
      op_done  <= ack_s ^ ack_prev;
      if (ack_s ^ ack_prev) begin
        op_rdata <= eng_rdata;
        op_hit   <= eng_hit;
      end
      if (cmd_clear && !clr_busy) clr_tgl <= ~clr_tgl;
      cmd_valid <= pend_s && !clr_busy && !cmd_clear;
      if (pend_s && !clr_busy) cmd_code <= lat_code;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_busy) |=> $stable(req_tgl));
  assert_clear_mask_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_clear |=> !cmd_valid);
endmodule

// File: rtl/cpbridge_top.sv
module cpbridge_top
  import cpbridge_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int TRY_W      = 16,
  parameter int NMI_CYCLES = 8,
  parameter int ADDR_LIMIT = 'h5800
) (
  input  logic             host_clk,
  input  logic             host_rst,
  input  logic             cpu_clk,
  input  logic             cpu_rst,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_io_rd,
  input  logic             cpu_io_wr,
  input  logic [DW-1:0]    bus_din,
  input  logic             busak,
  output logic             busrq,
  output logic             nmi,
  output logic [AW-1:0]    dma_addr,
  output logic [DW-1:0]    dma_dout,
  output logic             dma_mem_rd,
  output logic             dma_mem_wr,
  output logic             dma_io_rd,
  output logic             dma_io_wr,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic [AW-1:0]    op_addr,
  input  logic [DW-1:0]    op_wdata,
  input  logic             op_nmi,
  input  logic [TRY_W-1:0] op_tries,
  output logic             op_busy,
  output logic             op_done,
  output logic [DW-1:0]    op_rdata,
  output logic             op_hit,
  input  logic             cmd_clear,
  output logic             cmd_valid,
  output logic [1:0]       cmd_code
);
  logic             req_tgl, ack_t, res_hit, clr_tgl, pend, clr_ack_t, q_nmi;
  logic [2:0]       q_kind;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_wdata, res_rdata;
  logic [TRY_W-1:0] q_tries;
  cmd_code_e        code;

  cpbridge_host_port #(.AW(AW), .DW(DW), .TRY_W(TRY_W)) u_host (
    .clk(host_clk), .rst(host_rst),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_nmi(op_nmi), .op_tries(op_tries), .op_busy(op_busy), .op_done(op_done),
    .op_rdata(op_rdata), .op_hit(op_hit),
    .cmd_clear(cmd_clear), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .req_tgl(req_tgl), .q_kind(q_kind), .q_addr(q_addr), .q_wdata(q_wdata),
    .q_nmi(q_nmi), .q_tries(q_tries),
    .eng_ack_t(ack_t), .eng_rdata(res_rdata), .eng_hit(res_hit),
    .clr_tgl(clr_tgl), .lat_pend(pend), .lat_code(code), .lat_clr_ack_t(clr_ack_t));

  cpbridge_dma_engine #(.AW(AW), .DW(DW), .TRY_W(TRY_W),
                        .NMI_CYCLES(NMI_CYCLES), .ADDR_LIMIT(ADDR_LIMIT)) u_eng (
    .clk(cpu_clk), .rst(cpu_rst),
    .req_tgl(req_tgl), .op_kind(q_kind), .op_addr(q_addr), .op_wdata(q_wdata),
    .op_nmi(q_nmi), .op_tries(q_tries),
    .ack_t(ack_t), .res_rdata(res_rdata), .res_hit(res_hit),
    .busak(busak), .bus_din(bus_din), .cpu_addr(cpu_addr),
    .busrq(busrq), .nmi(nmi), .dma_addr(dma_addr), .dma_dout(dma_dout),
    .mem_rd(dma_mem_rd), .mem_wr(dma_mem_wr), .io_rd(dma_io_rd), .io_wr(dma_io_wr));

  cpbridge_cmd_latch u_cmd (
    .clk(cpu_clk), .rst(cpu_rst),
    .io_rd(cpu_io_rd), .io_wr(cpu_io_wr), .port(cpu_addr[7:0]),
    .clr_tgl(clr_tgl), .pend(pend), .code(code), .clr_ack_t(clr_ack_t));
endmodule

// File: tb/tb_cpbridge_top.sv
module tb_cpbridge_top;
  localparam int NMI_N = 8;

  logic host_clk = 0, cpu_clk = 0, host_rst = 1, cpu_rst = 1;
  logic [15:0] cpu_addr = '0;
  logic cpu_io_rd = 0, cpu_io_wr = 0, busak = 0;
  logic [7:0] bus_din;
  logic busrq, nmi, dma_mem_rd, dma_mem_wr, dma_io_rd, dma_io_wr;
  logic [15:0] dma_addr;
  logic [7:0] dma_dout;
  logic op_valid = 0, op_nmi = 0, cmd_clear = 0;
  logic [2:0] op_kind = '0;
  logic [15:0] op_addr = '0, op_tries = '0;
  logic [7:0] op_wdata = '0;
  logic op_busy, op_done, op_hit, cmd_valid;
  logic [7:0] op_rdata;
  logic [1:0] cmd_code;

  int tests = 0, fails = 0;
  int strobes = 0, bad_strobes = 0, nmi_hi = 0, nmi_overlap = 0, cmd_mism = 0;
  logic [1:0] exp_code = 2'd0;
  logic [7:0] mem [256];
  logic [7:0] iosp [256];
  logic bq1 = 0;
  logic [7:0] last_rdata;
  logic last_hit;

  always #5  host_clk = ~host_clk;
  always #20 cpu_clk  = ~cpu_clk;

  cpbridge_top #(.NMI_CYCLES(NMI_N)) dut (.*);

  // simple CPU-bus model: acknowledge lags request by two CPU cycles
  always_comb bus_din = dma_mem_rd ? mem[dma_addr[7:0]] :
                        dma_io_rd  ? iosp[dma_addr[7:0]] : 8'hFF;
  always @(posedge cpu_clk) begin
    bq1   <= busrq;
    busak <= bq1 && busrq;
    if (dma_mem_wr) mem[dma_addr[7:0]]  <= dma_dout;
    if (dma_io_wr)  iosp[dma_addr[7:0]] <= dma_dout;
    if (!cpu_rst) begin
      if (dma_mem_rd || dma_mem_wr || dma_io_rd || dma_io_wr) begin
        strobes++;
        if (!(busak && busrq)) bad_strobes++;
      end
      if (nmi) nmi_hi++;
      if (nmi && busrq) nmi_overlap++;
    end
  end

  // reference model of the host's command view, compared every host clock
  always @(negedge host_clk)
    if (!host_rst && cmd_valid && cmd_code != exp_code) cmd_mism++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_io(input bit wr, input logic [7:0] port);
    @(negedge cpu_clk);
    cpu_addr  = {8'hFE, port};
    cpu_io_rd = !wr;
    cpu_io_wr = wr;
    @(negedge cpu_clk);
    cpu_io_rd = 0;
    cpu_io_wr = 0;
  endtask

  task automatic settle();
    repeat (14) @(negedge cpu_clk);
  endtask

  task automatic clear_cmd(input logic [1:0] next_exp);
    @(negedge host_clk);
    cmd_clear = 1;
    @(negedge host_clk);
    cmd_clear = 0;
    exp_code  = next_exp;
  endtask

  task automatic hop(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d,
                     input bit n, input logic [15:0] t);
    int w = 0;
    @(negedge host_clk);
    op_valid = 1; op_kind = k; op_addr = a; op_wdata = d; op_nmi = n; op_tries = t;
    @(negedge host_clk);
    op_valid = 0;
    while (!op_done && w < 4000) begin @(negedge host_clk); w++; end
    if (!op_done) begin
      tests++; fails++;
      $display("FAIL R10 operation timeout actual=busy expected=done");
    end
    last_rdata = op_rdata;
    last_hit   = op_hit;
  endtask

  initial begin
    #3_000_000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0, n0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i); iosp[i] = 8'(i ^ 8'h5A); end
    repeat (4) @(negedge cpu_clk);
    host_rst = 0; cpu_rst = 0;
    @(negedge host_clk);
    // R11 reset state
    chk("R11 busrq", busrq, 0);
    chk("R11 nmi", nmi, 0);
    chk("R11 strobes", {dma_mem_rd, dma_mem_wr, dma_io_rd, dma_io_wr}, 0);
    chk("R11 cmd_valid", cmd_valid, 0);
    chk("R11 op_busy", op_busy, 0);
    chk("R11 op_done", op_done, 0);

    // R1 init command
    exp_code = 2'd1;
    cpu_io(0, 8'h17); settle();
    chk("R1 valid", cmd_valid, 1);
    chk("R1 code", cmd_code, 1);
    // R3 held while pending, then cleared
    cpu_io(0, 8'h19); cpu_io(1, 8'h19); settle();
    chk("R3 held code", cmd_code, 1);
    clear_cmd(2'd2);
    @(negedge host_clk);
    chk("R4 masked after clear", cmd_valid, 0);
    settle();
    chk("R3 cleared", cmd_valid, 0);
    // R2 list and load
    cpu_io(0, 8'h19); settle();
    chk("R2 list", {cmd_valid, cmd_code}, 3'b110);
    clear_cmd(2'd3); settle();
    cpu_io(1, 8'h19); settle();
    chk("R2 load", {cmd_valid, cmd_code}, 3'b111);
    clear_cmd(2'd0); settle();
    cpu_io(1, 8'h17); cpu_io(0, 8'h18); cpu_io(0, 8'h1F); settle();
    chk("R2 other ports ignored", cmd_valid, 0);

    // R4 clear against a new command at swept offsets
    for (int off = -1; off <= 6; off++) begin
      exp_code = 2'd2;
      cpu_io(0, 8'h19); settle();
      if (off < 0) cpu_io(1, 8'h19);
      clear_cmd(2'd3);
      if (off >= 0) begin
        repeat (off) @(negedge cpu_clk);
        cpu_io(1, 8'h19);
      end
      settle();
      if (off < 0)       chk("R4 command before clear dropped", cmd_valid, 0);
      else if (off >= 4) chk("R4 command after clear kept", {cmd_valid, cmd_code}, 3'b111);
      if (cmd_valid) begin clear_cmd(2'd0); settle(); end
      exp_code = 2'd0;
    end
    tests++;
    if (cmd_mism != 0) begin
      fails++;
      $display("FAIL R4 per-clock code mismatches actual=%0d expected=0", cmd_mism);
    end

    // R7 transfers without the bus
    s0 = strobes;
    hop(3'd2, 16'h4010, 8'h11, 0, 0);
    hop(3'd1, 16'h4010, 8'h00, 0, 0);
    chk("R7 no strobe", strobes - s0, 0);
    chk("R7 rdata zero", last_rdata, 0);
    chk("R7 memory untouched", mem[8'h10], 8'h10);

    // R5 bus request
    hop(3'd0, 0, 0, 0, 0);
    @(negedge cpu_clk);
    chk("R5 busrq", busrq, 1);
    chk("R5 busak seen", busak, 1);

    // R6 transfers
    s0 = strobes;
    hop(3'd2, 16'h4010, 8'hA5, 0, 0);
    chk("R6 mem write", mem[8'h10], 8'hA5);
    hop(3'd1, 16'h4010, 8'h00, 0, 0);
    chk("R6 mem read", last_rdata, 8'hA5);
    hop(3'd4, 16'h001F, 8'h3C, 0, 0);
    chk("R6 io write", iosp[8'h1F], 8'h3C);
    hop(3'd3, 16'h002E, 8'h00, 0, 0);
    chk("R6 io read", last_rdata, 8'h2E ^ 8'h5A);
    chk("R6 one strobe each", strobes - s0, 4);

    // R10 busy ignores new operations
    cpu_addr = 16'h1000;
    @(negedge host_clk);
    op_valid = 1; op_kind = 3'd6; op_tries = 16'd40;
    @(negedge host_clk);
    op_valid = 0;
    repeat (3) @(negedge host_clk);
    chk("R10 busy", op_busy, 1);
    op_valid = 1; op_kind = 3'd2; op_addr = 16'h4020; op_wdata = 8'h77;
    @(negedge host_clk);
    op_valid = 0;
    while (!op_done) @(negedge host_clk);
    chk("R10 busy low at done", op_busy, 0);
    @(negedge host_clk);
    chk("R10 done one cycle", op_done, 0);
    repeat (20) @(negedge cpu_clk);
    chk("R10 ignored write", mem[8'h20], 8'h20);

    // R8 release with and without the interrupt
    n0 = nmi_hi;
    hop(3'd5, 0, 0, 1, 0);
    @(negedge cpu_clk);
    chk("R8 nmi width", nmi_hi - n0, NMI_N);
    chk("R8 nmi not with busrq", nmi_overlap, 0);
    chk("R8 busrq dropped", busrq, 0);
    hop(3'd0, 0, 0, 0, 0);
    n0 = nmi_hi;
    hop(3'd5, 0, 0, 0, 0);
    repeat (4) @(negedge cpu_clk);
    chk("R8 no nmi", nmi_hi - n0, 0);

    // R9 address wait
    cpu_addr = 16'h1000; hop(3'd6, 0, 0, 0, 16'd6);
    chk("R9 timeout low", last_hit, 0);
    cpu_addr = 16'h5800; hop(3'd6, 0, 0, 0, 16'd6);
    chk("R9 equal misses", last_hit, 0);
    cpu_addr = 16'h5801; hop(3'd6, 0, 0, 0, 16'd6);
    chk("R9 above hits", last_hit, 1);
    cpu_addr = 16'h6000; hop(3'd6, 0, 0, 0, 16'd0);
    chk("R9 zero tries misses", last_hit, 0);
    cpu_addr = 16'h1000;
    fork
      hop(3'd6, 0, 0, 0, 16'd60);
      begin repeat (15) @(negedge cpu_clk); cpu_addr = 16'h7000; end
    join
    chk("R9 rising address hits", last_hit, 1);

    chk("R7 strobes only when granted", bad_strobes, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule